// File: doc/BRIEF.md
# Baseline-Referenced Multichannel Self-Trigger

This block watches several channels of 12-bit ADC samples, one sample period per clock tick (6.25 ns at 160 MSa/s), and decides when an event worth reading out has arrived. Each channel keeps its own running reference level, an exponential moving average of its samples. A channel counts as hot when its present sample is more than a shared programmable trigger level above that reference. When any channel that is not inhibited goes hot, the block emits a single-cycle trigger, reports the lowest-numbered hot channel, latches a timestamp from a free-running tick counter, and flags every non-inhibited channel for readout.

The reference stops moving while a channel is carrying test-pulse stimulus and while the channel is above threshold. Calibration pulses and real signal pulses therefore do not drag the reference upward. Once a trigger has fired, the block stays disarmed until every enabled channel has fallen back below threshold, so one long pulse yields one trigger. The averaging shift is programmable, and the current reference of each channel can always be read on a dedicated output bus.

Top module: `selftrig_top`

## Requirements
- R1: After reset each reference reads zero. The first valid sample on a channel that is not marked as test pulse loads the reference with that sample. That seeding sample can never cause a trigger.
- R2: Each later valid, non-test, below-threshold sample updates a 22-bit accumulator (12 integer bits, 10 fraction bits) as acc = acc + ((sample*1024 - acc) >>> k). The reference is acc/1024, rounded down. The shift k is taken from `avg_shift` and clamped to the range 4 to 10.
- R3: A sample whose test-pulse flag is set leaves that channel's reference unchanged, and it does not seed an unseeded channel.
- R4: A valid sample that is above threshold leaves that channel's reference unchanged.
- R5: A channel is above threshold only when its sample minus its reference is strictly greater than `trig_level`. Both values are treated as unsigned, so a sample at or below reference plus level never qualifies.
- R6: A qualifying sample on an enabled channel while the block is armed raises `trig_pulse` for exactly one cycle, in the clock cycle after that sample is presented.
- R7: A channel whose `inhibit` bit is 1 never causes a trigger.
- R8: On a trigger, `rd_mask` takes the bitwise inverse of `inhibit` (bit i = channel i). It holds that value until the next trigger.
- R9: When several enabled channels qualify in the same cycle, `trig_chan` reports the lowest channel index. `trig_chan` holds until the next trigger.
- R10: After a trigger, no further trigger fires until every enabled channel's latest valid sample has been below threshold. After that, the next qualifying sample fires again.
- R11: `trig_time` latches a 32-bit counter that advances by one every clock. The difference between two trigger timestamps equals the number of clock cycles between their qualifying samples.
- R12: A cycle in which a channel's valid strobe is low neither changes that channel's reference nor triggers on it, whatever its sample value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per sample period |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | NCH*SW | Packed samples, channel i at bits [i*SW +: SW] |
| smp_vld | input | NCH | Per-channel sample valid strobe |
| tp_active | input | NCH | Per-channel flag marking test-pulse stimulus |
| inhibit | input | NCH | Per-channel trigger and readout inhibit |
| trig_level | input | SW | Threshold above the reference |
| avg_shift | input | 4 | Averaging shift k, clamped to 4..10 |
| trig_pulse | output | 1 | Single-cycle trigger |
| trig_chan | output | CW | Lowest qualifying channel index |
| trig_time | output | 32 | Tick count latched at the qualifying sample |
| rd_mask | output | NCH | Channels flagged for readout |
| base_out | output | NCH*SW | Current reference per channel, same packing as smp_data |

## Verification
The bench puts samples exactly at reference plus level and one count above it. A design that used a non-strict compare, or a signed-versus-unsigned mistake, would then fire too early or fire on negative excursions. It drives averaging steps with shift settings below, inside and above the legal range and follows the accumulator to the count. A design that dropped the fraction bits or skipped the clamp would drift or step by the wrong amount. Test-pulse, above-threshold and idle samples are applied and the reference is read back afterwards, which catches a design that keeps averaging through them. Simultaneous crossings, inhibited channels and a pulse held over several samples check the priority order, the readout mask and the re-arm rule. A design that got any of these wrong would report the wrong channel, flag inhibited channels, or fire repeatedly on one pulse.

// File: rtl/selftrig_pkg.sv
package selftrig_pkg;
    localparam int FRAC_BITS = 10;
    localparam int K_MIN     = 4;
    localparam int K_MAX     = 10;
    localparam int TS_W      = 32;

    function automatic logic [3:0] clamp_shift(input logic [3:0] k);
        if (k < 4'(K_MIN))      return 4'(K_MIN);
        else if (k > 4'(K_MAX)) return 4'(K_MAX);
        else                    return k;
    endfunction
endpackage

// File: rtl/st_baseline.sv
module st_baseline #(
    parameter int SW   = 12,
    parameter int FRAC = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] smp,
    input  logic          vld,
    input  logic          tp,
    input  logic          hold,
    input  logic [3:0]    k,
    output logic [SW-1:0] base,
    output logic          seeded
);
    localparam int ACCW = SW + FRAC;

    typedef struct packed {
        logic            seeded;
        logic [ACCW-1:0] acc;
    } bl_state_t;

    bl_state_t st_d, st_q;
    logic signed [ACCW:0] target, delta, step;

    always_comb begin
        target = $signed({1'b0, smp, {FRAC{1'b0}}});
        delta  = target - $signed({1'b0, st_q.acc});
        step   = delta >>> k;
        st_d   = st_q;
        if (vld && !tp) begin
            if (!st_q.seeded) begin
                st_d.seeded = 1'b1;
                st_d.acc    = {smp, {FRAC{1'b0}}};
            end else if (!hold) begin
                st_d.acc = st_q.acc + step[ACCW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base   = st_q.acc[ACCW-1:FRAC];
    assign seeded = st_q.seeded;
endmodule

// File: rtl/st_compare.sv
module st_compare #(
    parameter int SW = 12
) (
    input  logic [SW-1:0] smp,
    input  logic [SW-1:0] base,
    input  logic [SW-1:0] level,
    input  logic          vld,
    input  logic          seeded,
    output logic          above
);
    logic signed [SW:0] excess;

    always_comb begin
        excess = $signed({1'b0, smp}) - $signed({1'b0, base});
        above  = vld && seeded && (excess > $signed({1'b0, level}));
    end
endmodule

// File: rtl/st_prio.sv
module st_prio #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [CW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/selftrig_top.sv
module selftrig_top #(
    parameter int NCH = 4,
    parameter int SW  = 12,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*SW-1:0]   smp_data,
    input  logic [NCH-1:0]      smp_vld,
    input  logic [NCH-1:0]      tp_active,
    input  logic [NCH-1:0]      inhibit,
    input  logic [SW-1:0]       trig_level,
    input  logic [3:0]          avg_shift,
    output logic                trig_pulse,
    output logic [CW-1:0]       trig_chan,
    output logic [31:0]         trig_time,
    output logic [NCH-1:0]      rd_mask,
    output logic [NCH*SW-1:0]   base_out
);
    import selftrig_pkg::*;

    typedef struct packed {
        logic            armed;
        logic [NCH-1:0]  hot;
        logic            pulse;
        logic [CW-1:0]   chan;
        logic [TS_W-1:0] stamp;
        logic [NCH-1:0]  mask;
        logic [TS_W-1:0] ticks;
    } trg_state_t;

    trg_state_t ts_d, ts_q;

    logic [3:0]     k_eff;
    logic [NCH-1:0] above, seeded, hit, cur_hot;
    logic           hit_any;
    logic [CW-1:0]  hit_idx;

    assign k_eff = clamp_shift(avg_shift);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [SW-1:0] base_c;

        st_baseline #(.SW(SW), .FRAC(FRAC_BITS)) i_base (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp    (smp_data[c*SW +: SW]),
            .vld    (smp_vld[c]),
            .tp     (tp_active[c]),
            .hold   (above[c]),
            .k      (k_eff),
            .base   (base_c),
            .seeded (seeded[c])
        );

        st_compare #(.SW(SW)) i_cmp (
            .smp    (smp_data[c*SW +: SW]),
            .base   (base_c),
            .level  (trig_level),
            .vld    (smp_vld[c]),
            .seeded (seeded[c]),
            .above  (above[c])
        );

        assign base_out[c*SW +: SW] = base_c;
        assign cur_hot[c] = smp_vld[c] ? above[c] : ts_q.hot[c];
    end

    assign hit = above & ~inhibit;

    st_prio #(.N(NCH), .CW(CW)) i_prio (
        .req (hit),
        .any (hit_any),
        .idx (hit_idx)
    );

    always_comb begin
        ts_d       = ts_q;
        ts_d.ticks = ts_q.ticks + 32'd1;
        ts_d.hot   = cur_hot;
        ts_d.pulse = 1'b0;
        if (ts_q.armed) begin
            if (hit_any) begin
                ts_d.armed = 1'b0;
                ts_d.pulse = 1'b1;
                ts_d.chan  = hit_idx;
                ts_d.stamp = ts_q.ticks;
                ts_d.mask  = ~inhibit;
            end
        end else if ((cur_hot & ~inhibit) == '0) begin
            ts_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q       <= '0;
            ts_q.armed <= 1'b1;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign trig_pulse = ts_q.pulse;
    assign trig_chan  = ts_q.chan;
    assign trig_time  = ts_q.stamp;
    assign rd_mask    = ts_q.mask;
endmodule

// File: rtl/selftrig_chk.sv
module selftrig_chk #(
    parameter int NCH = 4,
    parameter int SW  = 12,
    parameter int CW  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    smp_vld,
    input logic [NCH-1:0]    tp_active,
    input logic [NCH*SW-1:0] base_out,
    input logic              trig_pulse,
    input logic [CW-1:0]     trig_chan,
    input logic [31:0]       trig_time,
    input logic [NCH-1:0]    rd_mask
);
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) trig_pulse |=> !trig_pulse); // R6
    AST_ORIGIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) trig_pulse |-> rd_mask[trig_chan]); // R7
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n) !trig_pulse |-> $stable(rd_mask)); // R8
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n) !trig_pulse |-> $stable(trig_chan)); // R9
    AST_STAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n) !trig_pulse |-> $stable(trig_time)); // R11

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_TP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld[c] && tp_active[c]) |=> $stable(base_out[c*SW +: SW])); // R3
        AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld[c] |=> $stable(base_out[c*SW +: SW])); // R12
    end
endmodule

bind selftrig_top selftrig_chk #(.NCH(NCH), .SW(SW), .CW(CW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_vld    (smp_vld),
    .tp_active  (tp_active),
    .base_out   (base_out),
    .trig_pulse (trig_pulse),
    .trig_chan  (trig_chan),
    .trig_time  (trig_time),
    .rd_mask    (rd_mask)
);

// File: tb/test_selftrig_top.sv
module test_selftrig_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int SW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic [NCH-1:0]    smp_vld = '0;
    logic [NCH-1:0]    tp_active = '0;
    logic [NCH-1:0]    inhibit = '0;
    logic [SW-1:0]     trig_level = '0;
    logic [3:0]        avg_shift = 4'd4;
    logic              trig_pulse;
    logic [1:0]        trig_chan;
    logic [31:0]       trig_time;
    logic [NCH-1:0]    rd_mask;
    logic [NCH*SW-1:0] base_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [SW-1:0] s [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    selftrig_top #(.NCH(NCH), .SW(SW)) i_selftrig_top (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_vld(smp_vld),
        .tp_active(tp_active), .inhibit(inhibit), .trig_level(trig_level),
        .avg_shift(avg_shift), .trig_pulse(trig_pulse), .trig_chan(trig_chan),
        .trig_time(trig_time), .rd_mask(rd_mask), .base_out(base_out)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint base_of(input int c);
        return longint'(base_out[c*SW +: SW]);
    endfunction

    task automatic step(input logic [NCH-1:0] v, input logic [NCH-1:0] t);
        for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = s[c];
        smp_vld   = v;
        tp_active = t;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        smp_vld   = '0;
        tp_active = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_vld = '0; tp_active = '0; inhibit = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic seed_all(input logic [SW-1:0] val);
        for (int c = 0; c < NCH; c++) s[c] = val;
        step('1, '0);
    endtask

    task automatic t_reset_seed();
        do_reset();
        trig_level = 12'd4095;
        check("R1", "pulse after reset", trig_pulse, 0);
        check("R8", "mask after reset", rd_mask, 0);
        for (int c = 0; c < NCH; c++) check("R1", "ref after reset", base_of(c), 0);
        s[0] = 12'd500;
        step(4'b0001, 4'b0001);
        check("R3", "test pulse does not seed", base_of(0), 0);
        trig_level = 12'd0;
        for (int c = 0; c < NCH; c++) s[c] = 12'(100 * (c + 3));
        step('1, '0);
        check("R1", "seeding sample no trigger", trig_pulse, 0);
        for (int c = 0; c < NCH; c++) check("R1", "seeded ref", base_of(c), 100 * (c + 3));
    endtask

    task automatic ema_run(input logic [3:0] kin, input int keff, input int target, input int n, inout longint acc);
        avg_shift = kin;
        for (int i = 0; i < n; i++) begin
            s[0] = 12'(target);
            step(4'b0001, '0);
            acc = acc + (((longint'(target) <<< 10) - acc) >>> keff);
            check("R2", "ema ref", base_of(0), acc >>> 10);
        end
    endtask

    task automatic t_ema();
        longint acc;
        do_reset();
        trig_level = 12'd4095;
        seed_all(12'd1000);
        acc = longint'(1000) <<< 10;
        ema_run(4'd4, 4, 2000, 5, acc);
        ema_run(4'd2, 4, 500, 3, acc);
        ema_run(4'd15, 10, 3000, 4, acc);
        ema_run(4'd7, 7, 1001, 3, acc);
        check("R5", "no trigger at max level", trig_pulse, 0);
    endtask

    task automatic t_freeze();
        do_reset();
        trig_level = 12'd50;
        avg_shift = 4'd4;
        seed_all(12'd1000);
        s[1] = 12'd1040;
        step(4'b0010, 4'b0010);
        check("R3", "test pulse sample keeps ref", base_of(1), 1000);
        s[2] = 12'd1051;
        step(4'b0100, '0);
        check("R4", "above sample keeps ref", base_of(2), 1000);
        check("R6", "above sample triggers", trig_pulse, 1);
        s[3] = 12'd4000;
        step(4'b0000, '0);
        check("R12", "idle cycle keeps ref", base_of(3), 1000);
        check("R6", "pulse lasts one cycle", trig_pulse, 0);
    endtask

    task automatic t_strict();
        do_reset();
        trig_level = 12'd100;
        avg_shift = 4'd4;
        seed_all(12'd1000);
        s[0] = 12'd0;
        step(4'b0001, '0);
        check("R5", "below reference no trigger", trig_pulse, 0);
        do_reset();
        seed_all(12'd1000);
        s[0] = 12'd1100;
        step(4'b0001, '0);
        check("R5", "equal to level no trigger", trig_pulse, 0);
        do_reset();
        seed_all(12'd1000);
        s[0] = 12'd1101;
        step(4'b0001, '0);
        check("R5", "one above level triggers", trig_pulse, 1);
        check("R9", "origin channel", trig_chan, 0);
    endtask

    task automatic t_inhibit_prio();
        do_reset();
        trig_level = 12'd100;
        seed_all(12'd1000);
        inhibit = 4'b0010;
        s[1] = 12'd3000;
        step(4'b0010, '0);
        check("R7", "inhibited channel no trigger", trig_pulse, 0);
        s[1] = 12'd3000; s[2] = 12'd3000; s[3] = 12'd3000;
        step(4'b1110, '0);
        check("R7", "enabled channel triggers", trig_pulse, 1);
        check("R9", "lowest enabled hot channel", trig_chan, 2);
        check("R8", "readout mask", rd_mask, 4'b1101);
        do_reset();
        seed_all(12'd1000);
        inhibit = 4'b0100;
        s[1] = 12'd2000; s[3] = 12'd2000;
        step(4'b1010, '0);
        check("R9", "simultaneous crossing lowest wins", trig_chan, 1);
        check("R8", "readout mask two", rd_mask, 4'b1011);
        inhibit = 4'b0000;
        step('0, '0);
        check("R8", "mask held after trigger", rd_mask, 4'b1011);
    endtask

    task automatic t_rearm_time();
        longint t1;
        int n1;
        do_reset();
        trig_level = 12'd100;
        seed_all(12'd1000);
        s[0] = 12'd1500;
        step(4'b0001, '0);
        n1 = cyc;
        t1 = longint'(trig_time);
        check("R10", "first trigger", trig_pulse, 1);
        s[0] = 12'd1500; s[1] = 12'd1500;
        step(4'b0011, '0);
        check("R10", "held pulse no retrigger", trig_pulse, 0);
        s[0] = 12'd1000;
        step(4'b0001, '0);
        check("R10", "one channel still hot", trig_pulse, 0);
        s[2] = 12'd1500;
        step(4'b0100, '0);
        check("R10", "still disarmed", trig_pulse, 0);
        s[1] = 12'd1000; s[2] = 12'd1000;
        step(4'b0110, '0);
        check("R10", "all low rearm cycle", trig_pulse, 0);
        repeat (3) step('0, '0);
        s[3] = 12'd1200;
        step(4'b1000, '0);
        check("R10", "trigger after rearm", trig_pulse, 1);
        check("R11", "timestamp difference", longint'(trig_time) - t1, cyc - n1);
        check("R9", "second origin", trig_chan, 3);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) s[c] = '0;
        t_reset_seed();
        t_ema();
        t_freeze();
        t_strict();
        t_inhibit_prio();
        t_rearm_time();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule